// File: doc/BRIEF.md
# Age-Ordered Victim Selector for a Four-Way Set

This block holds only the replacement control state of one four-way cache set. It never sees tags, data or addresses. Each cycle it may accept one abstract symbol: a hit on a given way, or a miss. A miss makes the block name the way to evict. Every accepted symbol then updates a small age value kept for each way.

The ages always form a permutation of 0 to 3. Age 0 marks the most recently touched way and age 3 the stalest. A hit moves the touched way to age 0 and ages only the ways that were younger than it. A miss evicts the lowest-numbered way at age 3, moves that way to age 0 and ages every other way by one. The next state depends only on the current ages and the symbol received.

The surrounding cache presents symbols on a valid strobe. It reads the registered eviction result one cycle after a miss. The current age vector is exposed so that the state can be observed directly.

Top module: `age_repl_fsm`

## Requirements
- R1: While reset is high, the ages are set to 0, 1, 2 and 3 for ways 0, 1, 2 and 3. `ages_o` then reads 8'hE4, because way k occupies bits [2k+1:2k]. `vic_vld` and `vic_err` are low after reset.
- R2: A cycle with `sym_vld` low leaves `ages_o` unchanged and gives no eviction on the following cycle.
- R3: An accepted hit (`sym_miss` = 0) on way i works as follows. Way i goes to age 0. Each way whose age was below way i's old age gains one. Each way whose age was above it keeps its age. The new ages appear on `ages_o` in the next cycle.
- R4: An accepted miss (`sym_miss` = 1) raises `vic_vld` for exactly the next cycle. In that cycle `vic_way` holds the lowest way index whose age was 3 before the miss.
- R5: On an accepted miss, the victim way goes to age 0 and every other way gains one, saturating at 3.
- R6: After reset, exactly one way has each of the ages 0, 1, 2 and 3 in every cycle.
- R7: `vic_vld` is low in every cycle that does not directly follow an accepted miss. `sym_way` has no effect on a miss.
- R8: If no way holds age 3 when a miss is accepted, the block evicts way 0 and raises `vic_err` together with `vic_vld`. Because of R6, `vic_err` stays low on every sequence that starts from reset.
- R9: A hit on the way that is already at age 0 leaves all ages unchanged.
- R10: A hit on the way at age 3 sends that way to age 0 and adds one to each of the other three ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_vld | input | 1 | A symbol is presented this cycle |
| sym_miss | input | 1 | 1 = miss symbol, 0 = hit symbol |
| sym_way | input | 2 | Way index of a hit symbol |
| vic_way | output | 2 | Way chosen for eviction, valid with `vic_vld` |
| vic_vld | output | 1 | Eviction result valid, one cycle after a miss |
| vic_err | output | 1 | No way at age 3 was found on the miss |
| ages_o | output | 8 | Packed age per way, way k at bits [2k+1:2k] |

## Verification
Several directed patterns are applied, and each one separates cases a loose implementation could confuse:
- A hit on the youngest way shows whether the update is a true no-op (R9).
- A hit on the stalest way shows whether it behaves as a full move-to-front (R10).
- A hit on a middle-aged way shows whether the age comparison is strictly less-than (R3).
- Back-to-back misses test that the victim is taken from the state before each miss, not after it.
- A miss driven with an arbitrary way index shows that the index is ignored (R7).

A long random mix of idle cycles, hits and misses then reaches permutations that the directed cases do not. In every cycle the bench checks the age vector, the eviction strobe and index, the error flag and the permutation property against a reference model in the bench.

// File: rtl/age_repl_pkg.sv
package age_repl_pkg;

    localparam int unsigned DEF_WAYS = 4;

    typedef enum logic {
        SYM_HIT  = 1'b0,
        SYM_MISS = 1'b1
    } sym_kind_e;

    function automatic int unsigned oldest_age(input int unsigned ways);
        return ways - 1;
    endfunction

endpackage

// File: rtl/age_victim_scan.sv
module age_victim_scan #(
    parameter int unsigned NUM_WAYS = age_repl_pkg::DEF_WAYS,
    parameter int unsigned AGE_W    = $clog2(NUM_WAYS),
    parameter int unsigned IDX_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS*AGE_W-1:0] ages,
    output logic [NUM_WAYS-1:0]       at_max,
    output logic [IDX_W-1:0]          victim,
    output logic                      found
);
    localparam logic [AGE_W-1:0] MAX_AGE = AGE_W'(age_repl_pkg::oldest_age(NUM_WAYS));

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
        assign at_max[g] = (ages[g*AGE_W +: AGE_W] == MAX_AGE);
    end

    // Priority search: the lowest index wins because it is visited last.
    always_comb begin
        victim = '0;
        found  = 1'b0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (at_max[i]) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/age_next_state.sv
module age_next_state #(
    parameter int unsigned NUM_WAYS = age_repl_pkg::DEF_WAYS,
    parameter int unsigned AGE_W    = $clog2(NUM_WAYS),
    parameter int unsigned IDX_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS*AGE_W-1:0] ages,
    input  logic                      sym_vld,
    input  logic                      sym_miss,
    input  logic [IDX_W-1:0]          sym_way,
    input  logic [IDX_W-1:0]          victim,
    output logic [NUM_WAYS*AGE_W-1:0] ages_nxt
);
    import age_repl_pkg::*;

    localparam logic [AGE_W-1:0] MAX_AGE = AGE_W'(oldest_age(NUM_WAYS));

    sym_kind_e        kind;
    logic [AGE_W-1:0] ref_age;

    assign kind    = sym_kind_e'(sym_miss);
    assign ref_age = ages[sym_way*AGE_W +: AGE_W];

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        localparam logic [IDX_W-1:0] GI = IDX_W'(g);
        logic [AGE_W-1:0] cur;
        assign cur = ages[g*AGE_W +: AGE_W];

        always_comb begin
            ages_nxt[g*AGE_W +: AGE_W] = cur;
            if (sym_vld) begin
                if (kind == SYM_MISS) begin
                    if (victim == GI)
                        ages_nxt[g*AGE_W +: AGE_W] = '0;
                    else if (cur != MAX_AGE)
                        ages_nxt[g*AGE_W +: AGE_W] = cur + AGE_W'(1);
                end else begin
                    if (sym_way == GI)
                        ages_nxt[g*AGE_W +: AGE_W] = '0;
                    else if (cur < ref_age)
                        ages_nxt[g*AGE_W +: AGE_W] = cur + AGE_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/age_repl_fsm.sv
module age_repl_fsm #(
    parameter int unsigned NUM_WAYS = age_repl_pkg::DEF_WAYS,
    localparam int unsigned AGE_W   = $clog2(NUM_WAYS),
    localparam int unsigned IDX_W   = $clog2(NUM_WAYS),
    localparam int unsigned VEC_W   = NUM_WAYS * AGE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_vld,
    input  logic             sym_miss,
    input  logic [IDX_W-1:0] sym_way,
    output logic [IDX_W-1:0] vic_way,
    output logic             vic_vld,
    output logic             vic_err,
    output logic [VEC_W-1:0] ages_o
);
    typedef struct packed {
        logic             vld;
        logic             err;
        logic [IDX_W-1:0] way;
    } evict_t;

    logic [VEC_W-1:0]    age_q;
    logic [VEC_W-1:0]    age_d;
    logic [VEC_W-1:0]    age_init;
    logic [NUM_WAYS-1:0] at_max;
    logic [IDX_W-1:0]    victim;
    logic                found;
    evict_t              ev_q;
    evict_t              ev_d;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_init
        assign age_init[g*AGE_W +: AGE_W] = AGE_W'(g);
    end

    age_victim_scan #(.NUM_WAYS(NUM_WAYS), .AGE_W(AGE_W), .IDX_W(IDX_W)) i_scan (
        .ages   (age_q),
        .at_max (at_max),
        .victim (victim),
        .found  (found)
    );

    age_next_state #(.NUM_WAYS(NUM_WAYS), .AGE_W(AGE_W), .IDX_W(IDX_W)) i_next (
        .ages     (age_q),
        .sym_vld  (sym_vld),
        .sym_miss (sym_miss),
        .sym_way  (sym_way),
        .victim   (victim),
        .ages_nxt (age_d)
    );

    always_comb begin
        ev_d.vld = sym_vld & sym_miss;
        ev_d.err = sym_vld & sym_miss & ~found;
        ev_d.way = (sym_vld & sym_miss) ? victim : ev_q.way;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= age_init;
            ev_q  <= '0;
        end else begin
            age_q <= age_d;
            ev_q  <= ev_d;
        end
    end

    assign ages_o  = age_q;
    assign vic_way = ev_q.way;
    assign vic_vld = ev_q.vld;
    assign vic_err = ev_q.err;

    // R6: the set always holds exactly one stalest way
    a_r6_one_oldest: assert property (@(posedge clk) disable iff (rst)
        $countones(at_max) == 1);

    // R2: an idle cycle freezes the state
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !sym_vld |=> $stable(age_q));

    // R3: the hit way is youngest afterwards
    a_r3_hit_young: assert property (@(posedge clk) disable iff (rst)
        (sym_vld && !sym_miss) |=> age_q[$past(sym_way)*AGE_W +: AGE_W] == '0);

    // R5: the evicted way is youngest when the result is shown
    a_r5_victim_young: assert property (@(posedge clk) disable iff (rst)
        vic_vld |-> age_q[vic_way*AGE_W +: AGE_W] == '0);

    // R7: no eviction without a preceding miss
    a_r7_vld_cause: assert property (@(posedge clk) disable iff (rst)
        vic_vld |-> $past(sym_vld && sym_miss));

    // R8: error flag unreachable from reset
    a_r8_no_err: assert property (@(posedge clk) disable iff (rst)
        !vic_err);
endmodule

// File: tb/test_age_repl_fsm.sv
module test_age_repl_fsm;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_vld = 1'b0;
    logic       sym_miss = 1'b0;
    logic [1:0] sym_way = '0;
    logic [1:0] vic_way;
    logic       vic_vld;
    logic       vic_err;
    logic [7:0] ages_o;

    int total = 0;
    int bad   = 0;
    logic [7:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    age_repl_fsm i_age_repl_fsm (
        .clk      (clk),
        .rst      (rst),
        .sym_vld  (sym_vld),
        .sym_miss (sym_miss),
        .sym_way  (sym_way),
        .vic_way  (vic_way),
        .vic_vld  (vic_vld),
        .vic_err  (vic_err),
        .ages_o   (ages_o)
    );

    function automatic logic [1:0] ref_victim(input logic [7:0] a);
        for (int i = 0; i < 4; i++)
            if (a[i*2 +: 2] == 2'd3) return 2'(i);
        return 2'd0;
    endfunction

    function automatic logic [7:0] ref_next(input logic [7:0] a, input logic v,
                                            input logic m, input logic [1:0] w);
        logic [7:0] r = a;
        logic [1:0] vic = ref_victim(a);
        logic [1:0] hit_age = a[w*2 +: 2];
        if (!v) return a;
        for (int i = 0; i < 4; i++) begin
            if (m) begin
                if (2'(i) == vic) r[i*2 +: 2] = 2'd0;
                else if (a[i*2 +: 2] != 2'd3) r[i*2 +: 2] = a[i*2 +: 2] + 2'd1;
            end else begin
                if (2'(i) == w) r[i*2 +: 2] = 2'd0;
                else if (a[i*2 +: 2] < hit_age) r[i*2 +: 2] = a[i*2 +: 2] + 2'd1;
            end
        end
        return r;
    endfunction

    function automatic bit is_perm(input logic [7:0] a);
        logic [3:0] seen = '0;
        for (int i = 0; i < 4; i++) seen[a[i*2 +: 2]] = 1'b1;
        return seen == 4'hF;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic m, input logic [1:0] w,
                        input string age_req);
        logic [7:0] exp_a;
        logic [1:0] exp_w;
        logic       exp_v;
        string      rq;
        @(negedge clk);
        sym_vld = v; sym_miss = m; sym_way = w;
        exp_a = ref_next(model, v, m, w);
        exp_w = ref_victim(model);
        exp_v = v & m;
        @(posedge clk);
        #1;
        rq = (age_req != "") ? age_req : (!v ? "R2" : (m ? "R5" : "R3"));
        chk(ages_o == exp_a, rq, 32'(ages_o), 32'(exp_a));
        chk(vic_vld == exp_v, exp_v ? "R4" : "R7", 32'(vic_vld), 32'(exp_v));
        if (exp_v) chk(vic_way == exp_w, "R4", 32'(vic_way), 32'(exp_w));
        chk(vic_err == 1'b0, "R8", 32'(vic_err), 32'd0);
        chk(is_perm(ages_o), "R6", 32'(ages_o), 32'(exp_a));
        model = exp_a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20517));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(ages_o == 8'hE4, "R1", 32'(ages_o), 32'hE4);
        chk(vic_vld == 1'b0, "R1", 32'(vic_vld), 32'd0);
        chk(vic_err == 1'b0, "R1", 32'(vic_err), 32'd0);
        model = 8'hE4;

        step(1'b0, 1'b1, 2'd2, "R2");   // idle with miss bit set
        step(1'b1, 1'b0, 2'd0, "R9");   // hit youngest
        step(1'b1, 1'b0, 2'd3, "R10");  // hit stalest
        step(1'b1, 1'b0, 2'd1, "R3");   // hit middle age
        step(1'b1, 1'b1, 2'd3, "R7");   // miss with arbitrary index
        step(1'b1, 1'b1, 2'd0, "R5");   // back-to-back miss
        step(1'b1, 1'b1, 2'd1, "R5");
        step(1'b0, 1'b0, 2'd0, "R2");
        step(1'b1, 1'b0, 2'd2, "R3");

        for (int n = 0; n < 3000; n++) begin
            logic v = ($urandom % 4) != 0;
            logic m = 1'($urandom % 2);
            logic [1:0] w = 2'($urandom % 4);
            step(v, m, w, "");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule